// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block is the software-facing configuration and status front end of a multi-bank SDRAM controller. A device-control bus reaches it through two ports: an index port, which selects an internal register, and a data port, which reads or writes the selected register. Behind the data port sit the controller mode word, a read-only status word, refresh and power-down timer settings, one placement word per bank, an error-address register, two sticky error-status registers and the ECC configuration and status registers. Each register applies its own write mask, and some force fixed bits.

Turning the controller on or off through mode bit 31, and changing mode bit 30, updates bits of the status word. A nonzero ECC status drives an interrupt line. Each bank placement word packs a base address, a size code and a valid flag. A combinational decoder compares a probe address with every enabled bank and reports the bank that contains it.

Command sequencing, refresh generation and the data path sit in other blocks. Those blocks use the registered values and the bank decode.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A bus write to port 0x010 loads the 32-bit index register, and a read of that port returns the value unchanged. A read of any bus port other than 0x010 and 0x011 returns 0.
- R2: A data-port read returns 0xFFFFFFFF when the index holds the timing offset 0x80. It also returns 0xFFFFFFFF when the index holds an offset that names no register (for example 0x04, 0x50 or 0x100).
- R3: Data-port writes are masked before they are stored. Mode (0x20) keeps value & 0xFFE00000. Refresh (0x30) keeps value & 0x3FF80000. ECC config (0x94) keeps value & 0x00F00000. ECC status (0x98) keeps value & 0xFFF0F000. The power-down timer (0x34) keeps (value & 0xF8000000) | 0x07C00000. Error address (0x10) keeps all 32 bits.
- R4: The error-status registers at offsets 0x00 and 0x08 are sticky. Each bit is set by its set input on the next clock edge. A data-port write clears the bits written as 1. A set input wins over a clear in the same cycle.
- R5: Data-port writes to the status offset 0x24 have no effect. Status bit 31 clears when mode bit 31 changes from 0 to 1, and sets when it changes from 1 to 0. Status bit 30 sets when mode bit 30 changes from 0 to 1, and clears when it changes from 1 to 0. All other status bits read 0.
- R6: Bank n's placement word is at offset 0x40 + 4·n. It is stored as value & 0xFFDEE001. Bits 31:23 hold the base address, bits 19:17 hold the size code (size = 4 MiB << code) and bit 0 is the valid flag.
- R7: hit_o asserts for probe address A when some bank n meets all of these conditions: mode bit 31 is 1, bank n is valid, its size code is not 7, and base ≤ A < base + size. The range is computed without 32-bit wrap. hit_bank_o and the one-hot hit_vec_o give the lowest such n. When no bank matches, all three outputs are 0.
- R8: ecc_irq_o is high exactly while the stored ECC status is nonzero. It changes on the clock edge that stores the write.
- R9: After reset the registers hold these values: mode 0x00800000, refresh 0x05F00000, power-down timer 0x07C00000. The index, the error registers, error address, status, bank words and both ECC registers hold 0, and ecc_irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | BUS_AW | Device-control bus port address |
| bus_we_i | input | 1 | Bus write strobe |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data for bus_addr_i (combinational) |
| err_set_a_i | input | 32 | Set bits for error-status register at 0x00 |
| err_set_b_i | input | 32 | Set bits for error-status register at 0x08 |
| ecc_irq_o | output | 1 | ECC interrupt, high while ECC status is nonzero |
| probe_addr_i | input | 32 | Physical address to decode |
| hit_o | output | 1 | Probe address falls in an active bank |
| hit_bank_o | output | BANK_IW | Index of the winning bank |
| hit_vec_o | output | NUM_BANKS | One-hot winning bank |

## Verification
The bench builds the block with its defaults: four banks, a 10-bit bus address and the index and data ports at 0x010 and 0x011. With four banks, every placement slot can be addressed, and two banks can be given the same base so that the lowest-index priority is exercised. With the full 32-bit probe address, a bank placed at base 0xFF800000 with a 256 MiB size reaches past the top of the address space, which tests the range comparison that does not wrap. Random placement words cover every size code, including the invalid code 7. The probes concentrate near each bank's lower and upper bounds.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DW = 32;

  localparam logic [DW-1:0] OFS_ERR_A  = 32'h00;
  localparam logic [DW-1:0] OFS_ERR_B  = 32'h08;
  localparam logic [DW-1:0] OFS_EADDR  = 32'h10;
  localparam logic [DW-1:0] OFS_MODE   = 32'h20;
  localparam logic [DW-1:0] OFS_STAT   = 32'h24;
  localparam logic [DW-1:0] OFS_RFSH   = 32'h30;
  localparam logic [DW-1:0] OFS_PDT    = 32'h34;
  localparam logic [DW-1:0] OFS_BANK0  = 32'h40;
  localparam logic [DW-1:0] OFS_TIMING = 32'h80;
  localparam logic [DW-1:0] OFS_ECFG   = 32'h94;
  localparam logic [DW-1:0] OFS_ESTAT  = 32'h98;

  localparam logic [DW-1:0] MSK_MODE  = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_RFSH  = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_PDT   = 32'hF800_0000;
  localparam logic [DW-1:0] FRC_PDT   = 32'h07C0_0000;
  localparam logic [DW-1:0] MSK_BANK  = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_ECFG  = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_ESTAT = 32'hFFF0_F000;

  localparam logic [DW-1:0] RST_MODE  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RFSH  = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PDT   = 32'h07C0_0000;

  localparam int MODE_EN_BIT  = 31;
  localparam int MODE_AUX_BIT = 30;
  localparam int SIZE_LSB     = 17;
  localparam int BASE_LSB     = 23;
  localparam int MIN_SHIFT    = 22;

  typedef struct packed {
    logic [DW-1:BASE_LSB] base;
    logic [BASE_LSB-1:SIZE_LSB+3] rsv_hi;
    logic [2:0] size_code;
    logic [SIZE_LSB-1:1] rsv_lo;
    logic valid;
  } bank_word_t;

  function automatic logic [DW-1:0] bank_ofs(input int n);
    return OFS_BANK0 + DW'(4 * n);
  endfunction
endpackage

// File: rtl/sdram_cfg_sticky.sv
module sdram_cfg_sticky
  import sdram_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_we_i,
  input  logic [DW-1:0] clr_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q;
  logic [DW-1:0] clr_eff;

  assign clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_eff) | set_i;
  end

  assign q_o = q;

  a_r4_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q & $past(set_i)) == $past(set_i)));
  a_r4_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_i == '0) |=> $stable(q));
endmodule

// File: rtl/sdram_cfg_mode.sv
module sdram_cfg_mode
  import sdram_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mode_o,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] mode_q, mode_nx;
  logic          st_en_q, st_aux_q;

  assign mode_nx = wdata_i & MSK_MODE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= RST_MODE;
      st_en_q  <= 1'b0;
      st_aux_q <= 1'b0;
    end else if (we_i) begin
      mode_q <= mode_nx;
      if (!mode_q[MODE_EN_BIT] && mode_nx[MODE_EN_BIT])      st_en_q <= 1'b0;
      else if (mode_q[MODE_EN_BIT] && !mode_nx[MODE_EN_BIT]) st_en_q <= 1'b1;
      if (!mode_q[MODE_AUX_BIT] && mode_nx[MODE_AUX_BIT])      st_aux_q <= 1'b1;
      else if (mode_q[MODE_AUX_BIT] && !mode_nx[MODE_AUX_BIT]) st_aux_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign stat_o = {st_en_q, st_aux_q, {(DW-2){1'b0}}};

  a_r5_enable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q[MODE_EN_BIT]) |-> !st_en_q);
  a_r5_disable_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_q[MODE_EN_BIT]) |-> st_en_q);
  a_r5_aux_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q[MODE_AUX_BIT]) |-> st_aux_q);
  a_r3_mode_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> ((mode_q & ~MSK_MODE) == '0));
endmodule

// File: rtl/sdram_cfg_ecc.sv
module sdram_cfg_ecc
  import sdram_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          stat_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [DW-1:0] cfg_q, stat_q, stat_nx;
  logic          irq_q;

  assign stat_nx = wdata_i & MSK_ESTAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= wdata_i & MSK_ECFG;
      if (stat_we_i) begin
        stat_q <= stat_nx;
        irq_q  <= |stat_nx;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  a_r8_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q == (stat_q != '0));
  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> $stable(irq_q));
endmodule

// File: rtl/sdram_cfg_bank.sv
module sdram_cfg_bank
  import sdram_cfg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          enable_i,
  input  logic [DW-1:0] probe_i,
  output logic [DW-1:0] word_o,
  output logic          hit_o
);
  bank_word_t    word_q;
  logic [DW:0]   lo, span, hi, a_ext;
  logic          code_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (we_i) word_q <= bank_word_t'(wdata_i & MSK_BANK);
  end

  // 33-bit range so a window reaching past 4 GiB does not wrap
  assign lo      = {1'b0, word_q.base, {BASE_LSB{1'b0}}};
  assign span    = (DW+1)'(1) << (MIN_SHIFT + int'(word_q.size_code));
  assign hi      = lo + span;
  assign a_ext   = {1'b0, probe_i};
  assign code_ok = (word_q.size_code != 3'd7);
  assign hit_o   = enable_i && word_q.valid && code_ok && (a_ext >= lo) && (a_ext < hi);
  assign word_o  = word_q;

  a_r6_word_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o & ~MSK_BANK) == '0);
  a_r7_hit_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (enable_i && word_o[0]));
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdram_cfg_pkg::*;
#(
  parameter int            NUM_BANKS = 4,
  parameter int            BUS_AW    = 10,
  parameter logic [BUS_AW-1:0] IDX_PORT  = 10'h010,
  parameter logic [BUS_AW-1:0] DATA_PORT = 10'h011,
  localparam int           BANK_IW   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BUS_AW-1:0]    bus_addr_i,
  input  logic                 bus_we_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [31:0]          err_set_a_i,
  input  logic [31:0]          err_set_b_i,
  output logic                 ecc_irq_o,
  input  logic [31:0]          probe_addr_i,
  output logic                 hit_o,
  output logic [BANK_IW-1:0]   hit_bank_o,
  output logic [NUM_BANKS-1:0] hit_vec_o
);
  logic [DW-1:0] idx_q, eaddr_q, rfsh_q, pdt_q;
  logic [DW-1:0] err_q [2];
  logic [DW-1:0] mode_w, stat_w, ecfg_w, estat_w;
  logic [DW-1:0] bank_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;
  logic          idx_we, data_we;
  logic [DW-1:0] win_rd;

  assign idx_we  = bus_we_i && (bus_addr_i == IDX_PORT);
  assign data_we = bus_we_i && (bus_addr_i == DATA_PORT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      eaddr_q <= '0;
      rfsh_q  <= RST_RFSH;
      pdt_q   <= RST_PDT;
    end else begin
      if (idx_we) idx_q <= bus_wdata_i;
      if (data_we && idx_q == OFS_EADDR) eaddr_q <= bus_wdata_i;
      if (data_we && idx_q == OFS_RFSH)  rfsh_q  <= bus_wdata_i & MSK_RFSH;
      if (data_we && idx_q == OFS_PDT)   pdt_q   <= (bus_wdata_i & MSK_PDT) | FRC_PDT;
    end
  end

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_err
      localparam logic [DW-1:0] OFS = (g == 0) ? OFS_ERR_A : OFS_ERR_B;
      sdram_cfg_sticky u_sticky (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_we_i (data_we && idx_q == OFS),
        .clr_i    (bus_wdata_i),
        .set_i    ((g == 0) ? err_set_a_i : err_set_b_i),
        .q_o      (err_q[g])
      );
    end
  endgenerate

  sdram_cfg_mode u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (data_we && idx_q == OFS_MODE),
    .wdata_i (bus_wdata_i),
    .mode_o  (mode_w),
    .stat_o  (stat_w)
  );

  sdram_cfg_ecc u_ecc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (data_we && idx_q == OFS_ECFG),
    .stat_we_i (data_we && idx_q == OFS_ESTAT),
    .wdata_i   (bus_wdata_i),
    .cfg_o     (ecfg_w),
    .stat_o    (estat_w),
    .irq_o     (ecc_irq_o)
  );

  generate
    for (g = 0; g < NUM_BANKS; g++) begin : g_bank
      sdram_cfg_bank u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (data_we && idx_q == bank_ofs(g)),
        .wdata_i  (bus_wdata_i),
        .enable_i (mode_w[MODE_EN_BIT]),
        .probe_i  (probe_addr_i),
        .word_o   (bank_w[g]),
        .hit_o    (bank_hit[g])
      );
    end
  endgenerate

  // lowest index wins: scan downward, last match kept
  always_comb begin
    hit_o      = 1'b0;
    hit_bank_o = '0;
    hit_vec_o  = '0;
    for (int n = NUM_BANKS - 1; n >= 0; n--) begin
      if (bank_hit[n]) begin
        hit_o      = 1'b1;
        hit_bank_o = BANK_IW'(n);
        hit_vec_o  = NUM_BANKS'(1) << n;
      end
    end
  end

  always_comb begin
    unique case (idx_q)
      OFS_ERR_A:  win_rd = err_q[0];
      OFS_ERR_B:  win_rd = err_q[1];
      OFS_EADDR:  win_rd = eaddr_q;
      OFS_MODE:   win_rd = mode_w;
      OFS_STAT:   win_rd = stat_w;
      OFS_RFSH:   win_rd = rfsh_q;
      OFS_PDT:    win_rd = pdt_q;
      OFS_ECFG:   win_rd = ecfg_w;
      OFS_ESTAT:  win_rd = estat_w;
      default:    win_rd = '1;
    endcase
    for (int n = 0; n < NUM_BANKS; n++) begin
      if (idx_q == bank_ofs(n)) win_rd = bank_w[n];
    end
  end

  always_comb begin
    if (bus_addr_i == IDX_PORT)       bus_rdata_o = idx_q;
    else if (bus_addr_i == DATA_PORT) bus_rdata_o = win_rd;
    else                              bus_rdata_o = '0;
  end

  a_r7_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o) && (hit_o == (hit_vec_o != '0)));
  a_r7_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_w[MODE_EN_BIT] |-> !hit_o);
  a_r3_pdt_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdt_q & FRC_PDT) == FRC_PDT);
  a_r1_idx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_we |=> (idx_q == $past(bus_wdata_i)));
endmodule

// File: tb/sdram_cfg_regfile_bench.sv
module sdram_cfg_regfile_bench;
  localparam int NB = 4;
  localparam logic [9:0] PI = 10'h010;
  localparam logic [9:0] PD = 10'h011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] set_a = '0, set_b = '0;
  logic        irq;
  logic [31:0] probe = '0;
  logic        hit;
  logic [1:0]  hbank;
  logic [NB-1:0] hvec;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sdram_cfg_regfile u_sdram_cfg_regfile (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .err_set_a_i(set_a),
    .err_set_b_i(set_b), .ecc_irq_o(irq), .probe_addr_i(probe),
    .hit_o(hit), .hit_bank_o(hbank), .hit_vec_o(hvec));

  // reference model
  logic [31:0] m_idx, m_err_a, m_err_b, m_eaddr, m_mode, m_rfsh, m_pdt, m_ecfg, m_estat;
  logic        m_st31, m_st30;
  logic [31:0] m_bank [NB];

  task automatic model_reset();
    m_idx = 0; m_err_a = 0; m_err_b = 0; m_eaddr = 0; m_mode = 32'h0080_0000;
    m_rfsh = 32'h05F0_0000; m_pdt = 32'h07C0_0000; m_ecfg = 0; m_estat = 0;
    m_st31 = 0; m_st30 = 0;
    for (int i = 0; i < NB; i++) m_bank[i] = 0;
  endtask

  function automatic logic [31:0] exp_win(input logic [31:0] o);
    case (o)
      32'h00: return m_err_a;
      32'h08: return m_err_b;
      32'h10: return m_eaddr;
      32'h20: return m_mode;
      32'h24: return {m_st31, m_st30, 30'd0};
      32'h30: return m_rfsh;
      32'h34: return m_pdt;
      32'h40: return m_bank[0];
      32'h44: return m_bank[1];
      32'h48: return m_bank[2];
      32'h4C: return m_bank[3];
      32'h94: return m_ecfg;
      32'h98: return m_estat;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int exp_hit(input logic [31:0] a);
    if (!m_mode[31]) return -1;
    for (int b = 0; b < NB; b++) begin
      logic [32:0] base, lim;
      int code;
      code = int'(m_bank[b][19:17]);
      base = {1'b0, m_bank[b][31:23], 23'd0};
      lim  = base + (33'd4194304 << code);
      if (m_bank[b][0] && code != 7 && {1'b0, a} >= base && {1'b0, a} < lim) return b;
    end
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a == PI) m_idx = d;
    else if (a == PD) begin
      case (m_idx)
        32'h00: m_err_a &= ~d;
        32'h08: m_err_b &= ~d;
        32'h10: m_eaddr = d;
        32'h20: begin
          logic [31:0] nv;
          nv = d & 32'hFFE0_0000;
          if (!m_mode[31] && nv[31]) m_st31 = 0; else if (m_mode[31] && !nv[31]) m_st31 = 1;
          if (!m_mode[30] && nv[30]) m_st30 = 1; else if (m_mode[30] && !nv[30]) m_st30 = 0;
          m_mode = nv;
        end
        32'h30: m_rfsh = d & 32'h3FF8_0000;
        32'h34: m_pdt = (d & 32'hF800_0000) | 32'h07C0_0000;
        32'h40: m_bank[0] = d & 32'hFFDE_E001;
        32'h44: m_bank[1] = d & 32'hFFDE_E001;
        32'h48: m_bank[2] = d & 32'hFFDE_E001;
        32'h4C: m_bank[3] = d & 32'hFFDE_E001;
        32'h94: m_ecfg = d & 32'h00F0_0000;
        32'h98: m_estat = d & 32'hFFF0_F000;
        default: ;
      endcase
    end
  endtask

  task automatic win_write(input logic [31:0] o, input logic [31:0] d);
    bus_write(PI, o);
    bus_write(PD, d);
  endtask

  task automatic win_check(input string req, input logic [31:0] o);
    bus_write(PI, o);
    addr = PD; #1;
    chk(req, rdata, exp_win(o));
  endtask

  task automatic probe_check(input string req, input logic [31:0] a);
    int e;
    probe = a; #1;
    e = exp_hit(a);
    chk(req, {31'd0, hit}, {31'd0, e >= 0});
    chk(req, {30'd0, hbank}, (e >= 0) ? 32'(e) : 32'd0);
    chk(req, {28'd0, hvec}, (e >= 0) ? (32'd1 << e) : 32'd0);
  endtask

  task automatic pulse_err(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    set_a = a; set_b = b;
    @(negedge clk);
    set_a = 0; set_b = 0;
    m_err_a |= a; m_err_b |= b;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam logic [31:0] OFS_LIST [14] = '{32'h00, 32'h08, 32'h10, 32'h20, 32'h24, 32'h30,
    32'h34, 32'h40, 32'h44, 32'h48, 32'h4C, 32'h80, 32'h94, 32'h98};

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    addr = PI; #1; chk("R9", rdata, 32'h0);
    chk("R9", {31'd0, irq}, 32'd0);
    foreach (OFS_LIST[i]) if (OFS_LIST[i] != 32'h80) win_check("R9", OFS_LIST[i]);

    // R1 index readback and foreign ports
    bus_write(PI, 32'hDEAD_BEEF);
    addr = PI; #1; chk("R1", rdata, 32'hDEAD_BEEF);
    addr = 10'h000; #1; chk("R1", rdata, 32'h0);
    addr = 10'h3FF; #1; chk("R1", rdata, 32'h0);
    bus_write(10'h012, 32'h1234_5678);
    addr = PI; #1; chk("R1", rdata, 32'hDEAD_BEEF);

    // R2 timing and undefined offsets
    win_write(32'h80, 32'h0);
    win_check("R2", 32'h80);
    win_check("R2", 32'h04);
    win_check("R2", 32'h50);
    win_check("R2", 32'h100);

    // R3 masks
    win_write(32'h20, 32'hFFFF_FFFF); win_check("R3", 32'h20);
    win_write(32'h30, 32'hFFFF_FFFF); win_check("R3", 32'h30);
    win_write(32'h34, 32'h0);         win_check("R3", 32'h34);
    win_write(32'h94, 32'hFFFF_FFFF); win_check("R3", 32'h94);
    win_write(32'h10, 32'hA5A5_5A5A); win_check("R3", 32'h10);

    // R5 status transitions and read-only status
    win_check("R5", 32'h24);
    win_write(32'h24, 32'hFFFF_FFFF); win_check("R5", 32'h24);
    win_write(32'h20, 32'h0);         win_check("R5", 32'h24);
    win_write(32'h20, 32'h4000_0000); win_check("R5", 32'h24);
    win_write(32'h20, 32'h8000_0000); win_check("R5", 32'h24);

    // R4 sticky error registers
    pulse_err(32'h0000_00F0, 32'h8000_0001);
    win_check("R4", 32'h00); win_check("R4", 32'h08);
    win_write(32'h00, 32'h0000_0030); win_check("R4", 32'h00);
    // set wins over clear in same cycle
    bus_write(PI, 32'h08);
    @(negedge clk);
    addr = PD; wdata = 32'h8000_0001; we = 1'b1; set_b = 32'h8000_0000;
    @(negedge clk);
    we = 1'b0; set_b = 0;
    m_err_b = (m_err_b & ~32'h8000_0001) | 32'h8000_0000;
    addr = PD; #1; chk("R4", rdata, m_err_b);

    // R8 ECC interrupt
    win_write(32'h98, 32'h0000_0FFF);
    chk("R8", {31'd0, irq}, 32'd0);
    win_write(32'h98, 32'h0000_1000);
    chk("R8", {31'd0, irq}, 32'd1);
    win_write(32'h98, 32'h0);
    chk("R8", {31'd0, irq}, 32'd0);

    // R6/R7 directed bank cases
    win_write(32'h40, 32'h0080_0003 | (32'd1 << 17)); win_check("R6", 32'h40);
    win_write(32'h44, 32'h0080_0001 | (32'd3 << 17));
    win_write(32'h48, 32'h1000_0001 | (32'd7 << 17));
    win_write(32'h4C, 32'hFF80_0001 | (32'd6 << 17));
    probe_check("R7", 32'h0080_0000);
    probe_check("R7", 32'h0107_FFFF);
    probe_check("R7", 32'h0100_0000);
    probe_check("R7", 32'h0280_0000);
    probe_check("R7", 32'h1000_0000);
    probe_check("R7", 32'hFFFF_FFFF);
    probe_check("R7", 32'h007F_FFFF);
    win_write(32'h20, 32'h0);
    probe_check("R7", 32'h0080_0000);
    win_write(32'h20, 32'h8000_0000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k;
      logic [31:0] o, d;
      k = int'($urandom_range(0, 9));
      o = OFS_LIST[$urandom_range(0, 13)];
      d = $urandom;
      if (k < 4) begin
        win_write(o, d);
        win_check(o[7:0] >= 8'h40 && o[7:0] <= 8'h4C ? "R6" : "R3", o);
      end else if (k == 4) begin
        pulse_err($urandom & $urandom, $urandom & $urandom);
        win_check("R4", 32'h00);
      end else if (k == 5) begin
        win_write(32'h20, {d[31:30], 30'd0});
        win_check("R5", 32'h24);
      end else if (k == 6) begin
        win_write(32'h98, (it % 2 == 0) ? 32'h0 : d);
        chk("R8", {31'd0, irq}, {31'd0, m_estat != 0});
      end else begin
        int b;
        logic [32:0] base, span;
        b = int'($urandom_range(0, NB - 1));
        base = {1'b0, m_bank[b][31:23], 23'd0};
        span = 33'd4194304 << m_bank[b][19:17];
        case ($urandom_range(0, 3))
          0: r = base[31:0];
          1: r = 32'(base + span - 33'd1);
          2: r = 32'(base + span);
          default: r = 32'(base - 33'd1);
        endcase
        probe_check("R7", r);
        probe_check("R7", $urandom);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule